// File: doc/BRIEF.md
# Vector Lane Sum Reducer

This unit adds every integer lane of a source vector and returns one lane-wide total. A request carries a 128-bit source, a two-bit lane-size code, a width bit that chooses between the full 128-bit source and only its lower 64 bits, and a form bit. The form bit chooses between two operations. The across-vector sum adds all lanes of the chosen width. The pairwise scalar sum adds the two 64-bit halves of the full source.

The total is formed by repeated halving. At each level the upper half of the remaining piece is added lane by lane onto its lower half, and this continues until one lane is left. Every addition wraps at the lane width. The result is registered one cycle after the request and placed zero-extended into a 128-bit destination. Size, width and form combinations that the encoding reserves produce an illegal flag, and the destination keeps its previous contents.

Top module: `lane_sum_reduce`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_valid` and `res_illegal` become 0 and `res_data` becomes all zeros.
- R2: The lane width is 8 << `in_size` (00 gives 8 bits, 01 gives 16, 10 gives 32, 11 gives 64). In the across form (`in_pair`=0) with `in_wide`=1, the result is the sum of all lanes of `in_src[127:0]`, taken modulo 2^lane-width.
- R3: In the across form with `in_wide`=0, only `in_src[63:0]` is summed. Bits 127..64 of the source have no effect on the result.
- R4: In the pairwise form (`in_pair`=1) with `in_size`=11, the result is `in_src[63:0] + in_src[127:64]` modulo 2^64, and `in_wide` has no effect.
- R5: For a legal request, every bit of `res_data` at or above the lane width is zero. Bits 127..64 are always zero.
- R6: An across-form request with `in_size`=11, or with `in_size`=10 and `in_wide`=0, is reserved. It sets `res_illegal` and leaves `res_data` unchanged.
- R7: A pairwise request with any `in_size` other than 11 is reserved. It sets `res_illegal` and leaves `res_data` unchanged.
- R8: `res_valid` is high exactly in the cycle after a cycle with `in_valid` high. `res_illegal` is only high together with `res_valid`. With no request, `res_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_pair | input | 1 | 1 = pairwise scalar form, 0 = across-vector form |
| in_wide | input | 1 | 1 = 128-bit source, 0 = lower 64 bits only (across form) |
| in_size | input | 2 | Lane size code, lane width = 8 << code |
| in_src | input | 128 | Source vector, lane 0 in the lowest bits |
| res_valid | output | 1 | Result or illegal flag present this cycle |
| res_illegal | output | 1 | The previous request used a reserved combination |
| res_data | output | 128 | Zero-extended lane sum |

## Verification
The assertions assume that `in_size`, `in_wide` and `in_pair` carry known values whenever `in_valid` is high. They also assume that the request fields are only meaningful in the cycle in which `in_valid` is asserted. The stimulus drives every field from a fixed-seed random source only at falling edges and always with defined values, so reserved and legal combinations both appear many times. Directed cases add all-ones, sign-bit-only and carry-out patterns, a source whose upper half is non-zero while the lower width is selected, and idle gaps in which the held result is observed.

// File: rtl/lsr_pkg.sv
// Package for the lane sum reducer.
// Holds the vector geometry, the form encoding and the legality rule.
// Assumes lane widths are 8 << size and never exceed half the vector.
package lsr_pkg;
    localparam int VEC_W   = 128;
    localparam int HALF_W  = VEC_W / 2;
    localparam int SIZE_W  = 2;
    localparam int N_SIZES = 1 << SIZE_W;
    localparam int MIN_LW  = 8;

    typedef enum logic {
        FORM_ACROSS = 1'b0,
        FORM_PAIR   = 1'b1
    } lsr_form_e;

    // Lane width in bits for a size code
    function automatic int lane_bits(input logic [SIZE_W-1:0] code);
        return MIN_LW << code;
    endfunction
endpackage

// File: rtl/lsr_fold.sv
// One halving level: adds the upper half of a piece onto its lower half,
// lane by lane, with each lane wrapping at its own width.
// Assumes W is an even multiple of LW.
module lsr_fold #(
    parameter int W  = 128,
    parameter int LW = 8
) (
    input  logic [W-1:0]   din,
    output logic [W/2-1:0] dout
);
    localparam int HW = W / 2;
    localparam int NL = HW / LW;

    // One wrapping adder per lane of the lower half
    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign dout[i*LW +: LW] = din[i*LW +: LW] + din[HW + i*LW +: LW];
    end
endmodule

// File: rtl/lsr_tree.sv
// Recursive halving reducer: folds the vector in half until one lane
// remains. Assumes VEC_W / LW is a power of two.
module lsr_tree #(
    parameter int VEC_W = 128,
    parameter int LW    = 8
) (
    input  logic [VEC_W-1:0] vec,
    output logic [LW-1:0]    sum
);
    if (VEC_W == LW) begin : g_leaf
        // The piece is a single lane: pass it through
        assign sum = vec;
    end else begin : g_node
        logic [VEC_W/2-1:0] folded;

        lsr_fold #(.W(VEC_W), .LW(LW)) u_fold (
            .din  (vec),
            .dout (folded)
        );

        lsr_tree #(.VEC_W(VEC_W/2), .LW(LW)) u_sub (
            .vec (folded),
            .sum (sum)
        );
    end
endmodule

// File: rtl/lsr_decode.sv
// Request decoder: applies the reserved-combination rules and picks the
// operand width. Pairwise form always uses the full vector.
module lsr_decode
    import lsr_pkg::*;
(
    input  logic              form_pair,
    input  logic              wide,
    input  logic [SIZE_W-1:0] size,
    output logic              legal,
    output logic              full_width
);
    // Legality of size / width / form combination
    always_comb begin
        if (form_pair == FORM_PAIR) begin
            legal = (size == SIZE_W'(N_SIZES - 1));
        end else begin
            legal = !((size == SIZE_W'(N_SIZES - 1)) ||
                      (size == SIZE_W'(N_SIZES - 2) && !wide));
        end
    end

    // Operand width select
    assign full_width = (form_pair == FORM_PAIR) || wide;
endmodule

// File: rtl/lane_sum_reduce.sv
// Lane sum reducer top: one reduction tree per lane size, a size mux and
// a single result register. Reserved requests only raise the illegal flag.
// Assumes request fields are defined whenever in_valid is high.
module lane_sum_reduce
    import lsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_pair,
    input  logic              in_wide,
    input  logic [1:0]        in_size,
    input  logic [127:0]      in_src,
    output logic              res_valid,
    output logic              res_illegal,
    output logic [127:0]      res_data
);
    logic                         legal;
    logic                         full_width;
    logic [VEC_W-1:0]             operand;
    logic [N_SIZES-1:0][HALF_W-1:0] zsum;
    logic [HALF_W-1:0]            low_q;
    logic                         valid_q;
    logic                         illegal_q;

    lsr_decode u_dec (
        .form_pair  (in_pair),
        .wide       (in_wide),
        .size       (in_size),
        .legal      (legal),
        .full_width (full_width)
    );

    // Clear the upper half when only 64 bits take part
    assign operand = full_width ? in_src : {{HALF_W{1'b0}}, in_src[HALF_W-1:0]};

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        localparam int LW = MIN_LW << s;
        logic [LW-1:0] lane_sum;

        lsr_tree #(.VEC_W(VEC_W), .LW(LW)) u_tree (
            .vec (operand),
            .sum (lane_sum)
        );

        if (LW < HALF_W) begin : g_pad
            assign zsum[s] = {{(HALF_W-LW){1'b0}}, lane_sum};
        end else begin : g_full
            assign zsum[s] = lane_sum;
        end
    end

    // Result register: capture legal sums, flag reserved requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q     <= '0;
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            valid_q   <= in_valid;
            illegal_q <= in_valid && !legal;
            if (in_valid && legal) begin
                low_q <= zsum[in_size];
            end
        end
    end

    assign res_valid   = valid_q;
    assign res_illegal = illegal_q;
    assign res_data    = {{HALF_W{1'b0}}, low_q};
endmodule

// File: rtl/lsr_checker.sv
// Assertion checker for the lane sum reducer, bound to the top.
module lsr_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_pair,
    input logic         in_wide,
    input logic [1:0]   in_size,
    input logic         res_valid,
    input logic         res_illegal,
    input logic [127:0] res_data
);
    // Bits above the lane width of the previous request
    function automatic logic [127:0] above_lane(input logic [1:0] code);
        return ~({128{1'b1}} >> (128 - (8 << code)));
    endfunction

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && $stable(res_data)));
    a_r8_illegal_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> res_valid);
    a_r6_reserved_across: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_pair && (in_size == 2'b11 || (in_size == 2'b10 && !in_wide)))
        |=> (res_illegal && $stable(res_data)));
    a_r7_reserved_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pair && in_size != 2'b11) |=> (res_illegal && $stable(res_data)));
    a_r5_zero_above: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_illegal) |-> ((res_data & above_lane($past(in_size))) == 128'd0));
endmodule

bind lane_sum_reduce lsr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_pair     (in_pair),
    .in_wide     (in_wide),
    .in_size     (in_size),
    .res_valid   (res_valid),
    .res_illegal (res_illegal),
    .res_data    (res_data)
);

// File: tb/sim_lane_sum_reduce.sv
module sim_lane_sum_reduce;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_pair;
    logic         in_wide;
    logic [1:0]   in_size;
    logic [127:0] in_src;
    logic         res_valid;
    logic         res_illegal;
    logic [127:0] res_data;

    int           total = 0;
    int           bad = 0;
    logic [127:0] exp_data;

    always #5ns clk = ~clk;

    lane_sum_reduce u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pair(in_pair),
        .in_wide(in_wide), .in_size(in_size), .in_src(in_src),
        .res_valid(res_valid), .res_illegal(res_illegal), .res_data(res_data)
    );

    function automatic logic is_legal(input logic p, input logic w, input logic [1:0] sz);
        if (p) return sz == 2'b11;
        return !(sz == 2'b11 || (sz == 2'b10 && !w));
    endfunction

    function automatic logic [127:0] model(input logic p, input logic w,
                                           input logic [1:0] sz, input logic [127:0] s);
        int lw = 8 << sz;
        int width = (p || w) ? 128 : 64;
        logic [127:0] m = {128{1'b1}} >> (128 - lw);
        logic [127:0] acc = '0;
        for (int i = 0; i < width / lw; i++) acc = acc + ((s >> (i * lw)) & m);
        return acc & m;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic p, input logic w, input logic [1:0] sz,
                       input logic [127:0] s, input string req);
        logic ok = is_legal(p, w, sz);
        @(negedge clk);
        in_valid = 1'b1; in_pair = p; in_wide = w; in_size = sz; in_src = s;
        @(negedge clk);
        in_valid = 1'b0;
        in_src = {$urandom, $urandom, $urandom, $urandom};
        if (ok) exp_data = model(p, w, sz, s);
        check({req, " valid"}, 128'(res_valid), 128'd1);
        check({req, " illegal"}, 128'(res_illegal), 128'(!ok));
        check({req, " data"}, res_data, exp_data);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        check({req, " idle valid"}, 128'(res_valid), 128'd0);
        check({req, " idle data"}, res_data, exp_data);
    endtask

    initial begin
        #2ms;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; in_valid = 1'b0; in_pair = 1'b0; in_wide = 1'b0;
        in_size = 2'b00; in_src = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", 128'(res_valid), 128'd0);
        check("R1 illegal", 128'(res_illegal), 128'd0);
        check("R1 data", res_data, 128'd0);
        rst_n = 1'b1;
        exp_data = '0;

        // R2: all-ones bytes over 128 bits wrap to 0xF0
        run(1'b0, 1'b1, 2'b00, {128{1'b1}}, "R2 bytes ones");
        check("R2 byte wrap value", res_data, 128'hF0);
        run(1'b0, 1'b1, 2'b01, {8{16'h8000}}, "R2 halves sign");
        run(1'b0, 1'b1, 2'b10, {4{32'hFFFF_FFFF}}, "R2 words ones");
        // R3: narrow source ignores the upper half
        run(1'b0, 1'b0, 2'b00, {64'hFFFF_FFFF_FFFF_FFFF, {8{8'h80}}}, "R3 narrow bytes");
        check("R3 narrow value", res_data, 128'h0);
        run(1'b0, 1'b0, 2'b01, {64'h1234_5678_9ABC_DEF0, 64'h0001_0002_0003_0004}, "R3 narrow halves");
        check("R3 narrow halves value", res_data, 128'hA);
        // R4: pairwise halves, carry discarded, wide bit irrelevant
        run(1'b1, 1'b0, 2'b11, {64'h1, 64'hFFFF_FFFF_FFFF_FFFF}, "R4 pair carry");
        check("R4 pair value", res_data, 128'h0);
        run(1'b1, 1'b1, 2'b11, {64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF}, "R4 pair sum");
        // R6 / R7: reserved requests keep the destination
        run(1'b0, 1'b1, 2'b11, {128{1'b1}}, "R6 size3 across");
        run(1'b0, 1'b0, 2'b10, {128{1'b1}}, "R6 size2 narrow");
        run(1'b1, 1'b1, 2'b00, {128{1'b1}}, "R7 pair size0");
        // R8: idle cycles hold data and drop valid
        idle("R8");
        idle("R8");

        for (int n = 0; n < 300; n++) begin
            logic [1:0] sz = 2'($urandom);
            logic p = ($urandom % 4) == 0;
            logic w = 1'($urandom);
            // R5: zero-extension is covered by the full 128-bit data compare
            run(p, w, sz, {$urandom, $urandom, $urandom, $urandom}, "R5 random");
            if (($urandom % 8) == 0) idle("R8 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule